// File: doc/BRIEF.md
# Addressing-Mode Effective Address Sequencer

This block sits in front of the execute stage of an 8-bit processor core. It takes an opcode byte and sorts it into an addressing mode by looking at the opcode's low nibble (column) and high nibble (row). It then reads the operand bytes that follow the opcode, and any pointer bytes those operands name, through a byte-wide memory port that has a ready handshake. From these bytes it builds a 16-bit effective address. An immediate operand gives its own location, and a branch gives its target address. All multi-byte values in memory are little-endian: the low byte sits at the lower address.

The caller presents the opcode, the X and Y index registers, the stack pointer and `pc_i` on the cycle it raises `start_i`. `pc_i` is the address of the first byte after the opcode. The block holds these values for the whole sequence. When the address is ready it raises `done_o` for one cycle, together with the mode, the operand length and the illegal-opcode flag. A new start is accepted while the block is idle, and also in the cycle that reports completion, so that sequences can run back to back.

Top module: `addr_mode_seq`

## Requirements
- R1: `mode_o` uses these codes: 0 implied/accumulator, 1 immediate, 2 zero page, 3 zero page+X, 4 zero page+Y, 5 absolute, 6 absolute+X, 7 absolute+Y, 8 indirect jump, 9 relative, 10 (zp,X), 11 (zp),Y, 12 stack. The mode is chosen from the opcode's column and row. Examples: 0xA9 gives 1, 0x6C gives 8, 0xF0 gives 9, 0xA1 gives 10, 0xB1 gives 11, 0x48 gives 12.
- R2: `len_o` is the number of operand bytes: 0 for implied and stack, 1 for immediate, zero-page, relative and both indirect-indexed forms, and 2 for absolute, absolute-indexed and indirect.
- R3: Exactly 151 of the 256 opcode values are legal. Any other value, 0x80 and 0x89 among them, sets `illegal_o`, reports `done_o` on the cycle after the start with mode 0 and length 0, and issues no memory request.
- R4: Operand bytes are read from `pc_i` and then from `pc_i+1`. Absolute mode, including 0x20 and 0x4C, gives `ea_o` = {second byte, first byte}.
- R5: Zero-page, zero-page+X and zero-page+Y addresses are the operand plus the index, taken modulo 256, so the high byte is 0x00. Only 0x96 and 0xB6 index by Y.
- R6: Absolute-indexed addresses add the index to the full 16-bit base, with carry into the high byte. The index is Y for odd rows of column 9 and for 0xBE, and X for the other absolute-indexed opcodes.
- R7: (zp,X) reads its pointer low byte from (operand+X) mod 256 and its high byte from (operand+X+1) mod 256. `ea_o` is the assembled pointer.
- R8: (zp),Y reads its pointer from the operand address and from (operand+1) mod 256, then adds Y to the full 16-bit pointer.
- R9: The indirect jump 0x6C reads the pointer high byte from {operand high, operand low + 1 mod 256}, so a pointer at xxFF takes its high byte from xx00.
- R10: The relative target is `pc_i`+1 plus the sign-extended offset byte.
- R11: Stack-class opcodes (0x00, 0x08, 0x28, 0x40, 0x48, 0x60, 0x68) report `ea_o` = 0x0100 + `sp_i`, which always lies in page 1, and issue no memory request.
- R12: Immediate and implied opcodes finish on the cycle after the start with no memory request. Immediate reports `ea_o` = `pc_i`; implied reports `ea_o` = 0.
- R13: While `mem_req_o` is high and `mem_ready_i` is low, the request and `mem_addr_o` stay unchanged. A byte is taken only on a cycle where both are high.
- R14: `done_o` lasts one cycle unless `start_i` accepts a new sequence in that same cycle. A `start_i` raised while a fetch is in progress is ignored and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence for the presented opcode |
| opcode_i | input | 8 | Opcode byte |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| sp_i | input | 8 | Stack pointer |
| pc_i | input | 16 | Address of the first byte after the opcode |
| mem_rdata_i | input | 8 | Memory read data |
| mem_ready_i | input | 1 | Memory read data valid |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 16 | Effective address, immediate location or branch target |
| mode_o | output | 4 | Resolved addressing mode code |
| len_o | output | 2 | Operand byte count |
| illegal_o | output | 1 | Opcode is not legal |

## Verification
Two things can happen in the same cycle: reporting one result and accepting the next start. The bench raises `start_i` with a second opcode exactly in the cycle where `done_o` shows the first result. It checks that the first result is intact in that cycle and that the second sequence reads the right addresses and yields its own correct address. A related collision is also tested: a start pulse with a different opcode arrives while a fetch is stalled by a low `mem_ready_i`. That pulse must leave the pending result unchanged.

// File: rtl/ams_pkg.sv
package ams_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;
  localparam logic [DW-1:0] STACK_PAGE = 8'h01;

  typedef enum logic [3:0] {
    M_IMPL  = 4'd0,
    M_IMM   = 4'd1,
    M_ZP    = 4'd2,
    M_ZPX   = 4'd3,
    M_ZPY   = 4'd4,
    M_ABS   = 4'd5,
    M_ABX   = 4'd6,
    M_ABY   = 4'd7,
    M_IND   = 4'd8,
    M_REL   = 4'd9,
    M_IZX   = 4'd10,
    M_IZY   = 4'd11,
    M_STACK = 4'd12
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OP0, S_OP1, S_PLO, S_PHI, S_DONE
  } state_e;
endpackage

// File: rtl/ams_decode.sv
module ams_decode
  import ams_pkg::*;
(
  input  logic [DW-1:0] op_i,
  output mode_e         mode_o,
  output logic [1:0]    len_o,
  output logic          legal_o
);
  logic [3:0] row, col;
  logic       odd;
  logic [15:0] row_ok;
  mode_e      m;
  logic [1:0] l;

  assign row = op_i[7:4];
  assign col = op_i[3:0];
  assign odd = row[0];

  // legal rows per column, bit index = row
  always_comb begin
    unique case (col)
      4'h0:                row_ok = 16'hFEFF;
      4'h1, 4'h5, 4'h6,
      4'h8, 4'hD:          row_ok = 16'hFFFF;
      4'h2:                row_ok = 16'h0400;
      4'h4:                row_ok = 16'h5F04;
      4'h9:                row_ok = 16'hFEFF;
      4'hA:                row_ok = 16'h5F55;
      4'hC:                row_ok = 16'h5D54;
      4'hE:                row_ok = 16'hFDFF;
      default:             row_ok = 16'h0000;
    endcase
  end

  always_comb begin
    m = M_IMPL;
    l = 2'd0;
    unique case (col)
      4'h0: begin
        if (odd) begin
          m = M_REL; l = 2'd1;
        end else if (row == 4'h2) begin
          m = M_ABS; l = 2'd2;
        end else if (row == 4'h0 || row == 4'h4 || row == 4'h6) begin
          m = M_STACK;
        end else begin
          m = M_IMM; l = 2'd1;
        end
      end
      4'h1: begin
        m = odd ? M_IZY : M_IZX; l = 2'd1;
      end
      4'h2: begin
        m = M_IMM; l = 2'd1;
      end
      4'h4, 4'h5, 4'h6: begin
        l = 2'd1;
        if (!odd)                             m = M_ZP;
        else if (op_i == 8'h96 || op_i == 8'hB6) m = M_ZPY;
        else                                  m = M_ZPX;
      end
      4'h8: m = row[0] ? M_IMPL : (row[3] ? M_IMPL : M_STACK);
      4'h9: begin
        if (odd) begin
          m = M_ABY; l = 2'd2;
        end else begin
          m = M_IMM; l = 2'd1;
        end
      end
      4'hC, 4'hD, 4'hE: begin
        l = 2'd2;
        if (!odd)                m = (op_i == 8'h6C) ? M_IND : M_ABS;
        else if (op_i == 8'hBE)  m = M_ABY;
        else                     m = M_ABX;
      end
      default: m = M_IMPL;
    endcase
  end

  assign legal_o = row_ok[row];
  assign mode_o  = legal_o ? m : M_IMPL;
  assign len_o   = legal_o ? l : 2'd0;
endmodule

// File: rtl/ams_seq.sv
module ams_seq
  import ams_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          nxt_legal_i,
  input  mode_e         nxt_mode_i,
  input  mode_e         cur_mode_i,
  input  logic [1:0]    cur_len_i,
  input  logic [DW-1:0] x_i,
  input  logic [AW-1:0] pc_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          accept_o,
  output state_e        state_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] op_lo_o,
  output logic [DW-1:0] op_hi_o,
  output logic [DW-1:0] ptr_lo_o,
  output logic [DW-1:0] ptr_hi_o
);
  state_e state_q, state_d;
  logic [DW-1:0] base_lo, ptr_page;
  logic          take;

  assign accept_o  = start_i && (state_q == S_IDLE || state_q == S_DONE);
  assign mem_req_o = (state_q == S_OP0) || (state_q == S_OP1) ||
                     (state_q == S_PLO) || (state_q == S_PHI);
  assign take      = mem_req_o && mem_ready_i;
  assign state_o   = state_q;

  // pointer location; 8-bit add wraps inside its page
  assign base_lo  = (cur_mode_i == M_IZX) ? DW'(op_lo_o + x_i) : op_lo_o;
  assign ptr_page = (cur_mode_i == M_IND) ? op_hi_o : '0;

  always_comb begin
    unique case (state_q)
      S_OP0:   mem_addr_o = pc_i;
      S_OP1:   mem_addr_o = pc_i + AW'(1);
      S_PLO:   mem_addr_o = {ptr_page, base_lo};
      S_PHI:   mem_addr_o = {ptr_page, DW'(base_lo + DW'(1))};
      default: mem_addr_o = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE, S_DONE: begin
        if (accept_o) begin
          if (!nxt_legal_i || nxt_mode_i == M_IMPL ||
              nxt_mode_i == M_STACK || nxt_mode_i == M_IMM)
            state_d = S_DONE;
          else
            state_d = S_OP0;
        end else begin
          state_d = S_IDLE;
        end
      end
      S_OP0: if (take) begin
        if (cur_len_i == 2'd2)                               state_d = S_OP1;
        else if (cur_mode_i == M_IZX || cur_mode_i == M_IZY) state_d = S_PLO;
        else                                                 state_d = S_DONE;
      end
      S_OP1: if (take) state_d = (cur_mode_i == M_IND) ? S_PLO : S_DONE;
      S_PLO: if (take) state_d = S_PHI;
      S_PHI: if (take) state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_lo_o  <= '0;
      op_hi_o  <= '0;
      ptr_lo_o <= '0;
      ptr_hi_o <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        unique case (state_q)
          S_OP0:   op_lo_o  <= mem_rdata_i;
          S_OP1:   op_hi_o  <= mem_rdata_i;
          S_PLO:   ptr_lo_o <= mem_rdata_i;
          S_PHI:   ptr_hi_o <= mem_rdata_i;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ams_ea_calc.sv
module ams_ea_calc
  import ams_pkg::*;
(
  input  mode_e         mode_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] ptr_lo_i,
  input  logic [DW-1:0] ptr_hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] ea_o
);
  logic [AW-1:0] opw, ptrw, xw, yw, offs;

  assign opw  = {op_hi_i, op_lo_i};
  assign ptrw = {ptr_hi_i, ptr_lo_i};
  assign xw   = AW'(x_i);
  assign yw   = AW'(y_i);
  assign offs = {{(AW-DW){op_lo_i[DW-1]}}, op_lo_i};

  always_comb begin
    unique case (mode_i)
      M_IMM:   ea_o = pc_i;
      M_ZP:    ea_o = {{(AW-DW){1'b0}}, op_lo_i};
      M_ZPX:   ea_o = {{(AW-DW){1'b0}}, DW'(op_lo_i + x_i)};
      M_ZPY:   ea_o = {{(AW-DW){1'b0}}, DW'(op_lo_i + y_i)};
      M_ABS:   ea_o = opw;
      M_ABX:   ea_o = opw + xw;
      M_ABY:   ea_o = opw + yw;
      M_IND,
      M_IZX:   ea_o = ptrw;
      M_IZY:   ea_o = ptrw + yw;
      M_REL:   ea_o = pc_i + AW'(1) + offs;
      M_STACK: ea_o = {STACK_PAGE, sp_i};
      default: ea_o = '0;
    endcase
  end
endmodule

// File: rtl/addr_mode_seq.sv
module addr_mode_seq
  import ams_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic [7:0]    x_i,
  input  logic [7:0]    y_i,
  input  logic [7:0]    sp_i,
  input  logic [15:0]   pc_i,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          mem_req_o,
  output logic [15:0]   mem_addr_o,
  output logic          done_o,
  output logic [15:0]   ea_o,
  output logic [3:0]    mode_o,
  output logic [1:0]    len_o,
  output logic          illegal_o
);
  logic [DW-1:0] op_q, x_q, y_q, sp_q;
  logic [AW-1:0] pc_q;
  logic          accept;
  state_e        state_q;
  mode_e         nxt_mode, cur_mode;
  logic [1:0]    nxt_len, cur_len;
  logic          nxt_legal, cur_legal;
  logic [DW-1:0] op_lo, op_hi, ptr_lo, ptr_hi;

  // incoming opcode steers the accept branch; held opcode drives outputs
  ams_decode u_dec_nxt (.op_i(opcode_i), .mode_o(nxt_mode), .len_o(nxt_len), .legal_o(nxt_legal));
  ams_decode u_dec_cur (.op_i(op_q),     .mode_o(cur_mode), .len_o(cur_len), .legal_o(cur_legal));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= 8'hEA;
      x_q  <= '0;
      y_q  <= '0;
      sp_q <= '0;
      pc_q <= '0;
    end else if (accept) begin
      op_q <= opcode_i;
      x_q  <= x_i;
      y_q  <= y_i;
      sp_q <= sp_i;
      pc_q <= pc_i;
    end
  end

  ams_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .nxt_legal_i (nxt_legal),
    .nxt_mode_i  (nxt_mode),
    .cur_mode_i  (cur_mode),
    .cur_len_i   (cur_len),
    .x_i         (x_q),
    .pc_i        (pc_q),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .accept_o    (accept),
    .state_o     (state_q),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .op_lo_o     (op_lo),
    .op_hi_o     (op_hi),
    .ptr_lo_o    (ptr_lo),
    .ptr_hi_o    (ptr_hi)
  );

  ams_ea_calc u_ea (
    .mode_i   (cur_mode),
    .op_lo_i  (op_lo),
    .op_hi_i  (op_hi),
    .ptr_lo_i (ptr_lo),
    .ptr_hi_i (ptr_hi),
    .x_i      (x_q),
    .y_i      (y_q),
    .sp_i     (sp_q),
    .pc_i     (pc_q),
    .ea_o     (ea_o)
  );

  assign done_o    = (state_q == S_DONE);
  assign mode_o    = cur_mode;
  assign len_o     = cur_len;
  assign illegal_o = !cur_legal;
endmodule

// File: rtl/ams_checker.sv
module ams_checker
  import ams_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_req_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          done_o,
  input logic [AW-1:0] ea_o,
  input logic [3:0]    mode_o,
  input logic [1:0]    len_o,
  input logic          illegal_o,
  input state_e        state_q
);
  p_abs_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_o == M_ABS || mode_o == M_ABX || mode_o == M_ABY || mode_o == M_IND) |-> len_o == 2'd2);

  p_illegal_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_o && len_o == 2'd0);

  p_zp_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_o == M_ZP || mode_o == M_ZPX || mode_o == M_ZPY) |-> ea_o[AW-1:DW] == '0);

  p_ptr_page_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PLO || state_q == S_PHI) && (mode_o == M_IZX || mode_o == M_IZY)
    |-> mem_addr_o[AW-1:DW] == '0);

  p_stack_page_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_o == M_STACK |-> ea_o[AW-1:DW] == STACK_PAGE);

  p_hold_addr_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  p_done_pulse_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  p_no_req_done_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
endmodule

bind addr_mode_seq ams_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .done_o      (done_o),
  .ea_o        (ea_o),
  .mode_o      (mode_o),
  .len_o       (len_o),
  .illegal_o   (illegal_o),
  .state_q     (state_q)
);

// File: tb/addr_mode_seq_tb_top.sv
`timescale 1ns/1ps
module addr_mode_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = 8'hEA, x_i = '0, y_i = '0, sp_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  mem_rdata_i;
  logic        mem_ready_i;
  logic        mem_req_o, done_o, illegal_o;
  logic [15:0] mem_addr_o, ea_o;
  logic [3:0]  mode_o;
  logic [1:0]  len_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic stall_en = 1'b0, tog = 1'b0, clr_rd = 1'b0;
  int n_rd = 0;
  logic [15:0] rd_addr [0:7];

  logic [15:0] r_ea;
  logic [3:0]  r_mode;
  logic [1:0]  r_len;
  logic        r_ill;
  int          r_cyc;

  always #2.5 clk_i = ~clk_i;

  // memory content: byte = low ^ (high*7) ^ 0x3C
  function automatic logic [7:0] mf(input logic [15:0] a);
    logic [7:0] h;
    h = a[15:8] * 8'd7;
    return a[7:0] ^ h ^ 8'h3C;
  endfunction

  assign mem_rdata_i = mf(mem_addr_o);
  assign mem_ready_i = !stall_en || tog;
  always @(negedge clk_i) tog <= ~tog;

  always @(posedge clk_i) begin
    if (clr_rd) n_rd <= 0;
    else if (mem_req_o && mem_ready_i) begin
      if (n_rd < 8) rd_addr[n_rd] <= mem_addr_o;
      n_rd <= n_rd + 1;
    end
  end

  addr_mode_seq dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] x, input logic [7:0] y,
                       input logic [7:0] sp, input logic [15:0] pc);
    opcode_i = op; x_i = x; y_i = y; sp_i = sp; pc_i = pc;
    start_i = 1'b1; clr_rd = 1'b1;
  endtask

  task automatic wait_done();
    r_cyc = 0;
    while (!done_o && r_cyc < 50) begin
      @(negedge clk_i);
      r_cyc++;
    end
    r_ea = ea_o; r_mode = mode_o; r_len = len_o; r_ill = illegal_o;
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] x, input logic [7:0] y,
                     input logic [7:0] sp, input logic [15:0] pc);
    @(negedge clk_i);
    drive(op, x, y, sp, pc);
    @(negedge clk_i);
    start_i = 1'b0; clr_rd = 1'b0;
    wait_done();
  endtask

  task automatic t_reset();
    chk("R14 reset done", 16'(done_o), 16'd0);
    chk("R13 reset req", 16'(mem_req_o), 16'd0);
    chk("R3 reset illegal", 16'(illegal_o), 16'd0);
  endtask

  task automatic t_imm_impl_stack();
    run(8'hA9, 8'h00, 8'h00, 8'h00, 16'h1234);
    chk("R12 imm ea", r_ea, 16'h1234);
    chk("R1 imm mode", 16'(r_mode), 16'd1);
    chk("R2 imm len", 16'(r_len), 16'd1);
    chk("R12 imm reads", 16'(n_rd), 16'd0);
    chk("R12 imm latency", 16'(r_cyc), 16'd0);
    run(8'hAA, 8'h00, 8'h00, 8'h00, 16'h1234);
    chk("R1 implied mode", 16'(r_mode), 16'd0);
    chk("R12 implied ea", r_ea, 16'h0000);
    chk("R2 implied len", 16'(r_len), 16'd0);
    run(8'h48, 8'h00, 8'h00, 8'h7F, 16'h1234);
    chk("R11 stack ea", r_ea, 16'h017F);
    chk("R1 stack mode", 16'(r_mode), 16'd12);
    chk("R11 stack reads", 16'(n_rd), 16'd0);
    run(8'h60, 8'h00, 8'h00, 8'hFF, 16'h1234);
    chk("R11 stack ea top", r_ea, 16'h01FF);
  endtask

  task automatic t_zero_page();
    logic [7:0] lo;
    lo = mf(16'h0300);
    run(8'hB5, 8'hF0, 8'h00, 8'h00, 16'h0300);
    chk("R5 zpx wrap ea", r_ea, {8'h00, 8'(lo + 8'hF0)});
    chk("R1 zpx mode", 16'(r_mode), 16'd3);
    chk("R2 zp len", 16'(r_len), 16'd1);
    run(8'hB6, 8'h11, 8'hE0, 8'h00, 16'h0300);
    chk("R5 zpy ea", r_ea, {8'h00, 8'(lo + 8'hE0)});
    chk("R1 zpy mode", 16'(r_mode), 16'd4);
    run(8'hA5, 8'h11, 8'h22, 8'h00, 16'h0300);
    chk("R5 zp ea", r_ea, {8'h00, lo});
    chk("R1 zp mode", 16'(r_mode), 16'd2);
  endtask

  task automatic t_absolute();
    logic [15:0] base;
    base = {mf(16'h4001), mf(16'h4000)};
    run(8'hBD, 8'hFF, 8'h00, 8'h00, 16'h4000);
    chk("R6 absx carry ea", r_ea, base + 16'h00FF);
    chk("R1 absx mode", 16'(r_mode), 16'd6);
    chk("R2 abs len", 16'(r_len), 16'd2);
    chk("R4 first read", rd_addr[0], 16'h4000);
    chk("R4 second read", rd_addr[1], 16'h4001);
    run(8'hBE, 8'h01, 8'hC0, 8'h00, 16'h4000);
    chk("R6 absy ldx ea", r_ea, base + 16'h00C0);
    chk("R1 absy mode", 16'(r_mode), 16'd7);
    run(8'h79, 8'h01, 8'h33, 8'h00, 16'h4000);
    chk("R6 absy col9 ea", r_ea, base + 16'h0033);
    run(8'h20, 8'h01, 8'h02, 8'h00, 16'h4000);
    chk("R4 jsr ea", r_ea, base);
    chk("R1 jsr mode", 16'(r_mode), 16'd5);
    run(8'h4C, 8'h01, 8'h02, 8'h00, 16'h4000);
    chk("R4 jmp ea", r_ea, base);
  endtask

  task automatic t_indexed_indirect();
    logic [7:0] lo, xv;
    lo = mf(16'h0600);
    xv = 8'hFF - lo;
    run(8'hA1, xv, 8'h00, 8'h00, 16'h0600);
    chk("R7 izx ptr lo addr", rd_addr[1], 16'h00FF);
    chk("R7 izx ptr hi wrap", rd_addr[2], 16'h0000);
    chk("R7 izx ea", r_ea, {mf(16'h0000), mf(16'h00FF)});
    chk("R1 izx mode", 16'(r_mode), 16'd10);
    chk("R7 izx reads", 16'(n_rd), 16'd3);
  endtask

  task automatic t_indirect_indexed();
    logic [7:0] lo;
    logic [15:0] ptr;
    lo = mf(16'h0700);
    ptr = {mf({8'h00, 8'(lo + 8'h01)}), mf({8'h00, lo})};
    run(8'hB1, 8'h05, 8'hF0, 8'h00, 16'h0700);
    chk("R8 izy ptr lo addr", rd_addr[1], {8'h00, lo});
    chk("R8 izy ptr hi addr", rd_addr[2], {8'h00, 8'(lo + 8'h01)});
    chk("R8 izy ea", r_ea, ptr + 16'h00F0);
    chk("R1 izy mode", 16'(r_mode), 16'd11);
  endtask

  task automatic t_indirect_jump();
    logic [7:0] hi;
    chk("R9 setup pointer low is FF", 16'(mf(16'h2023)), 16'h00FF);
    hi = mf(16'h2024);
    run(8'h6C, 8'h00, 8'h00, 8'h00, 16'h2023);
    chk("R9 ind lo addr", rd_addr[2], {hi, 8'hFF});
    chk("R9 ind hi addr same page", rd_addr[3], {hi, 8'h00});
    chk("R9 ind ea", r_ea, {mf({hi, 8'h00}), mf({hi, 8'hFF})});
    chk("R1 ind mode", 16'(r_mode), 16'd8);
  endtask

  task automatic t_relative();
    logic [7:0] o;
    o = mf(16'h8000);
    run(8'hF0, 8'h00, 8'h00, 8'h00, 16'h8000);
    chk("R10 rel backward", r_ea, 16'h8001 + {{8{o[7]}}, o});
    chk("R1 rel mode", 16'(r_mode), 16'd9);
    o = mf(16'h0200);
    run(8'h10, 8'h00, 8'h00, 8'h00, 16'h0200);
    chk("R10 rel forward", r_ea, 16'h0201 + {{8{o[7]}}, o});
  endtask

  task automatic t_illegal_sweep();
    int legal_cnt;
    legal_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      run(8'(i), 8'h00, 8'h00, 8'h00, 16'h0900);
      if (!r_ill) legal_cnt++;
      else begin
        chk("R3 illegal no reads", 16'(n_rd), 16'd0);
        chk("R3 illegal latency", 16'(r_cyc), 16'd0);
        chk("R3 illegal mode/len", {12'(r_mode), 2'b00, r_len}, 16'd0);
      end
    end
    chk("R3 legal count", 16'(legal_cnt), 16'd151);
    run(8'h89, 8'h00, 8'h00, 8'h00, 16'h0900);
    chk("R3 0x89 illegal", 16'(r_ill), 16'd1);
    run(8'h80, 8'h00, 8'h00, 8'h00, 16'h0900);
    chk("R3 0x80 illegal", 16'(r_ill), 16'd1);
  endtask

  task automatic t_stall_and_busy();
    logic [15:0] base;
    base = {mf(16'h4001), mf(16'h4000)};
    stall_en = 1'b1;
    run(8'hBD, 8'h10, 8'h00, 8'h00, 16'h4000);
    chk("R13 stalled absx ea", r_ea, base + 16'h0010);
    chk("R13 stalled read count", 16'(n_rd), 16'd2);
    @(negedge clk_i);
    drive(8'hAD, 8'h00, 8'h00, 8'h00, 16'h4000);
    @(negedge clk_i);
    clr_rd = 1'b0;
    opcode_i = 8'hA9; pc_i = 16'h1111;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    chk("R14 busy start ignored ea", r_ea, base);
    chk("R14 busy start ignored mode", 16'(r_mode), 16'd5);
    stall_en = 1'b0;
  endtask

  task automatic t_back_to_back();
    logic [7:0] lo;
    lo = mf(16'h0500);
    @(negedge clk_i);
    drive(8'hA5, 8'h00, 8'h00, 8'h00, 16'h0500);
    @(negedge clk_i);
    start_i = 1'b0; clr_rd = 1'b0;
    wait_done();
    drive(8'hBD, 8'h01, 8'h00, 8'h00, 16'h4000);
    chk("R14 first result in overlap cycle", ea_o, {8'h00, lo});
    @(negedge clk_i);
    start_i = 1'b0; clr_rd = 1'b0;
    chk("R14 done not repeated", 16'(done_o), 16'd0);
    wait_done();
    chk("R14 second result", r_ea, {mf(16'h4001), mf(16'h4000)} + 16'h0001);
    chk("R14 second reads", rd_addr[0], 16'h4000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_imm_impl_stack();
    t_zero_page();
    t_absolute();
    t_indexed_indirect();
    t_indirect_indexed();
    t_indirect_jump();
    t_relative();
    t_stall_and_busy();
    t_back_to_back();
    t_illegal_sweep();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule